// File: doc/BRIEF.md
# Byte-Serial Flash-to-SRAM Pixel Loader

This block copies a colour image out of a byte-wide nonvolatile memory into a 16-bit-wide SRAM. The source stores each pixel as three consecutive bytes: red first, then green, then blue. The loader fetches the three bytes one at a time and keeps the upper bits of each. It packs them into a single 5-6-5 word and writes that word to the next SRAM location. The load repeats until a set number of pixels has been stored.

The flash is slow, so the loader holds off between accesses. A single start pulse begins the job. The loader first sits in a long warm-up wait. After every flash read it waits a programmable number of cycles, and after every flash address step it waits the same number again. A two-bit stage code reports warm-up, loading and completion. A done flag rises at the end and stays high until reset. The flash port is synchronous, and the byte it returns is valid in the cycle that follows the read strobe.

Top module: `rgb_flash_loader`

## Requirements
- R1: While reset is asserted and after it is released, the flash address and the SRAM address are 0. The read strobe and write strobe are low, the stage code is 0 and done is low.
- R2: A start pulse sampled while idle moves the stage code to 1 for exactly BOOT_CYC cycles, and the first read strobe follows right after. A start pulse sampled at any other time has no effect.
- R3: For each pixel, the loader issues three one-cycle read strobes in the order red, green, blue. The flash addresses are consecutive, and the first pixel starts at address 0.
- R4: A flash byte is taken only in the cycle directly after its read strobe (one-cycle read latency). Bus values in every other cycle are ignored.
- R5: After each read strobe there is one capture cycle followed by WAIT_CYC wait cycles. Then comes one increment cycle, after which the flash address is one higher. Then come WAIT_CYC more wait cycles before the next access.
- R6: The stored word carries red[7:3] in bits 15:11, green[7:2] in bits 10:5 and blue[7:3] in bits 4:0.
- R7: One single-cycle write strobe follows the blue byte's second wait. The SRAM address starts at 0 and goes up by one after each write.
- R8: After PIX_COUNT writes, the stage code is 3 and done is high. No further read or write strobe occurs, and done stays high until reset, even if start is pulsed again.
- R9: From the first read strobe until the last write, the stage code is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begins a load when the block is idle |
| fl_addr_o | output | 22 | Flash byte address |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_data_i | input | 8 | Flash byte, valid the cycle after the strobe |
| sr_addr_o | output | 18 | SRAM word address |
| sr_wdata_o | output | 16 | Packed 5-6-5 pixel |
| sr_we_o | output | 1 | SRAM write strobe |
| stage_o | output | 2 | 0 idle, 1 warm-up, 2 loading, 3 finished |
| done_o | output | 1 | Load complete, held until reset |

## Verification
On every cycle, the assertions check the local properties of the block. Each strobe lasts one cycle. Both addresses only ever step up by one, and the SRAM address never reaches the pixel limit on a write. The wait counter counts down steadily, and the finished state holds. The following properties need the reference model's cycle-exact trace:

- the exact cycle spacing of reads and writes around the waits;
- the red-green-blue order;
- the field placement of the packed word;
- taking flash data in the latency cycle only, while junk is driven on the bus in every other cycle;
- ignoring start pulses during a load and after completion.

// File: rtl/lw_pkg.sv
package lw_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_BOOT,
      ST_RD,
      ST_CAP,
      ST_W1,
      ST_INC,
      ST_W2,
      ST_WR,
      ST_DONE
   } ld_state_e;

   localparam logic [1:0] STAGE_IDLE = 2'd0;
   localparam logic [1:0] STAGE_BOOT = 2'd1;
   localparam logic [1:0] STAGE_LOAD = 2'd2;
   localparam logic [1:0] STAGE_DONE = 2'd3;

   localparam int NUM_CHAN = 3;

endpackage

// File: rtl/lw_delay_ctr.sv
module lw_delay_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] preset_i,
   output logic          zero_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (load_i)            cnt_q <= preset_i;
      else if (cnt_q != '0)       cnt_q <= cnt_q - CW'(1);
   end

   assign zero_o = (cnt_q == '0);

   // R5: wait count falls by one per cycle unless reloaded
   p_wait_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

endmodule

// File: rtl/lw_chan_bank.sv
module lw_chan_bank #(
   parameter int DW    = 8,
   parameter int NCHAN = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cap_i,
   input  logic [1:0]               sel_i,
   input  logic [DW-1:0]            data_i,
   output logic [NCHAN-1:0][DW-1:0] chan_o
);

   for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
      always_ff @(posedge clk) begin
         if (!rst_n)                              chan_o[ch] <= '0;
         else if (cap_i && sel_i == 2'(ch))       chan_o[ch] <= data_i;
      end
   end

endmodule

// File: rtl/lw_px_pack.sv
module lw_px_pack #(
   parameter int DW = 8,
   parameter int RW = 5,
   parameter int GW = 6,
   parameter int BW = 5,
   parameter int OW = 16
) (
   input  logic [DW-1:0] r_i,
   input  logic [DW-1:0] g_i,
   input  logic [DW-1:0] b_i,
   output logic [OW-1:0] px_o
);

   if (RW + GW + BW != OW) begin : g_bad_fields
      $error("colour field widths must fill the output word");
   end
   if (RW > DW || GW > DW || BW > DW) begin : g_bad_width
      $error("colour field wider than a source byte");
   end

   assign px_o = {r_i[DW-1 -: RW], g_i[DW-1 -: GW], b_i[DW-1 -: BW]};

   logic unused_low_bits;
   assign unused_low_bits = ^{r_i, g_i, b_i};

endmodule

// File: rtl/rgb_flash_loader.sv
module rgb_flash_loader
   import lw_pkg::*;
#(
   parameter int FA_W      = 22,
   parameter int FD_W      = 8,
   parameter int SA_W      = 18,
   parameter int SD_W      = 16,
   parameter int R_BITS    = 5,
   parameter int G_BITS    = 6,
   parameter int B_BITS    = 5,
   parameter int WAIT_CYC  = 100,
   parameter int BOOT_CYC  = 1000,
   parameter int PIX_COUNT = 213200
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   output logic [FA_W-1:0] fl_addr_o,
   output logic            fl_rd_o,
   input  logic [FD_W-1:0] fl_data_i,
   output logic [SA_W-1:0] sr_addr_o,
   output logic [SD_W-1:0] sr_wdata_o,
   output logic            sr_we_o,
   output logic [1:0]      stage_o,
   output logic            done_o
);

   localparam int MAXW = (BOOT_CYC > WAIT_CYC) ? BOOT_CYC : WAIT_CYC;
   localparam int CW   = $clog2(MAXW + 1);
   localparam logic [SA_W-1:0] LAST_PIX = SA_W'(PIX_COUNT - 1);

   if (WAIT_CYC < 1 || BOOT_CYC < 1) begin : g_bad_wait
      $error("wait lengths must be at least one cycle");
   end
   if (PIX_COUNT < 1 || longint'(PIX_COUNT) > (longint'(1) << SA_W)) begin : g_bad_pix
      $error("pixel count does not fit the SRAM address");
   end
   if (longint'(PIX_COUNT) * NUM_CHAN > (longint'(1) << FA_W)) begin : g_bad_flash
      $error("image does not fit the flash address space");
   end

   ld_state_e       state_q, state_d;
   logic [1:0]      chan_q;
   logic [FA_W-1:0] fa_q;
   logic [SA_W-1:0] sa_q;
   logic            wait_zero;
   logic            ctr_load;
   logic [CW-1:0]   ctr_preset;
   logic [NUM_CHAN-1:0][FD_W-1:0] chan_bytes;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)   state_d = ST_BOOT;
         ST_BOOT: if (wait_zero) state_d = ST_RD;
         ST_RD:                  state_d = ST_CAP;
         ST_CAP:                 state_d = ST_W1;
         ST_W1:   if (wait_zero) state_d = ST_INC;
         ST_INC:                 state_d = ST_W2;
         ST_W2:   if (wait_zero) state_d = (chan_q == 2'(NUM_CHAN - 1)) ? ST_WR : ST_RD;
         ST_WR:                  state_d = (sa_q == LAST_PIX) ? ST_DONE : ST_RD;
         ST_DONE:                state_d = ST_DONE;
         default:                state_d = ST_IDLE;
      endcase
   end

   assign ctr_load   = (state_d != state_q) &&
                       (state_d == ST_BOOT || state_d == ST_W1 || state_d == ST_W2);
   assign ctr_preset = (state_d == ST_BOOT) ? CW'(BOOT_CYC - 1) : CW'(WAIT_CYC - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         chan_q  <= '0;
         fa_q    <= '0;
         sa_q    <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_INC) fa_q <= fa_q + FA_W'(1);
         if (state_q == ST_W2 && wait_zero)
            chan_q <= (chan_q == 2'(NUM_CHAN - 1)) ? 2'd0 : chan_q + 2'd1;
         if (state_q == ST_WR) sa_q <= sa_q + SA_W'(1);
      end
   end

   lw_delay_ctr #(.CW(CW)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (ctr_load),
      .preset_i (ctr_preset),
      .zero_o   (wait_zero)
   );

   lw_chan_bank #(.DW(FD_W), .NCHAN(NUM_CHAN)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (state_q == ST_CAP),
      .sel_i  (chan_q),
      .data_i (fl_data_i),
      .chan_o (chan_bytes)
   );

   lw_px_pack #(.DW(FD_W), .RW(R_BITS), .GW(G_BITS), .BW(B_BITS), .OW(SD_W)) u_pack (
      .r_i  (chan_bytes[0]),
      .g_i  (chan_bytes[1]),
      .b_i  (chan_bytes[2]),
      .px_o (sr_wdata_o)
   );

   assign fl_addr_o = fa_q;
   assign sr_addr_o = sa_q;
   assign fl_rd_o   = (state_q == ST_RD);
   assign sr_we_o   = (state_q == ST_WR);
   assign done_o    = (state_q == ST_DONE);

   always_comb begin
      unique case (state_q)
         ST_IDLE: stage_o = STAGE_IDLE;
         ST_BOOT: stage_o = STAGE_BOOT;
         ST_DONE: stage_o = STAGE_DONE;
         default: stage_o = STAGE_LOAD;
      endcase
   end

   // R3: read strobe lasts a single cycle
   p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd_o |=> !fl_rd_o);

   // R3: flash address only ever steps up by one
   p_fa_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fl_addr_o) |-> (fl_addr_o == $past(fl_addr_o) + FA_W'(1)));

   // R7: write strobe lasts a single cycle and advances the SRAM address
   p_sa_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we_o |=> (!sr_we_o && sr_addr_o == $past(sr_addr_o) + SA_W'(1)));

   // R8: no write at or beyond the pixel limit
   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we_o |-> (int'(sr_addr_o) < PIX_COUNT));

   // R8: finished state is held with both strobes quiet
   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (done_o && !fl_rd_o && !sr_we_o));

   // R9: every memory access happens in the loading stage
   p_stage_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_rd_o || sr_we_o) |-> (stage_o == STAGE_LOAD));

endmodule

// File: tb/sim_rgb_flash_loader.sv
module sim_rgb_flash_loader;

   localparam int WAITN = 3;
   localparam int BOOTN = 6;
   localparam int PIXN  = 4;

   typedef struct packed {
      logic        rd;
      logic [31:0] fa;
      logic        we;
      logic [31:0] sa;
      logic [15:0] wd;
      logic [1:0]  stage;
      logic        done;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        start_i = 0;
   logic [21:0] fl_addr_o;
   logic        fl_rd_o;
   logic [7:0]  fl_data_i = 0;
   logic [17:0] sr_addr_o;
   logic [15:0] sr_wdata_o;
   logic        sr_we_o;
   logic [1:0]  stage_o;
   logic        done_o;

   int n_checks = 0;
   int n_fails  = 0;
   int cyc      = 0;
   exp_t q[$];

   always #10 clk = ~clk;

   rgb_flash_loader #(
      .WAIT_CYC(WAITN), .BOOT_CYC(BOOTN), .PIX_COUNT(PIXN)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .fl_addr_o(fl_addr_o), .fl_rd_o(fl_rd_o), .fl_data_i(fl_data_i),
      .sr_addr_o(sr_addr_o), .sr_wdata_o(sr_wdata_o), .sr_we_o(sr_we_o),
      .stage_o(stage_o), .done_o(done_o)
   );

   function automatic logic [7:0] fmem(int a);
      return 8'((a * 53 + 29) ^ (a >> 3));
   endfunction

   function automatic logic [15:0] pack565(logic [7:0] r, logic [7:0] g, logic [7:0] b);
      return {r[7:3], g[7:2], b[7:3]};
   endfunction

   // flash model: one-cycle latency, junk on the bus when not read (R4)
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (fl_rd_o) fl_data_i <= fmem(int'(fl_addr_o));
      else         fl_data_i <= 8'h5A ^ 8'(cyc);
   end

   initial begin
      #4000000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   task automatic check(string tag, string what, longint act, longint exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
      end
   endtask

   function automatic exp_t mk(logic rd, int fa, logic we, int sa, logic [15:0] wd,
                               logic [1:0] st, logic dn);
      exp_t e;
      e.rd = rd; e.fa = fa; e.we = we; e.sa = sa; e.wd = wd; e.stage = st; e.done = dn;
      return e;
   endfunction

   task automatic build_trace();
      q.delete();
      for (int i = 0; i < BOOTN; i++) q.push_back(mk(0, 0, 0, 0, 0, 2'd1, 0));
      for (int p = 0; p < PIXN; p++) begin
         for (int c = 0; c < 3; c++) begin
            int a = 3 * p + c;
            q.push_back(mk(1, a, 0, 0, 0, 2'd2, 0));
            q.push_back(mk(0, a, 0, 0, 0, 2'd2, 0));
            for (int w = 0; w < WAITN; w++) q.push_back(mk(0, a, 0, 0, 0, 2'd2, 0));
            q.push_back(mk(0, a, 0, 0, 0, 2'd2, 0));
            for (int w = 0; w < WAITN; w++) q.push_back(mk(0, a + 1, 0, 0, 0, 2'd2, 0));
         end
         q.push_back(mk(0, 3 * p + 3, 1, p,
                        pack565(fmem(3 * p), fmem(3 * p + 1), fmem(3 * p + 2)), 2'd2, 0));
      end
      for (int i = 0; i < 4; i++) q.push_back(mk(0, 3 * PIXN, 0, 0, 0, 2'd3, 1));
   endtask

   task automatic compare(exp_t e);
      check("R2 R9", "stage", stage_o, e.stage);
      check("R3", "read strobe", fl_rd_o, e.rd);
      check("R5", "flash address", fl_addr_o, e.fa);
      check("R7", "write strobe", sr_we_o, e.we);
      check("R8", "done", done_o, e.done);
      if (e.we) begin
         check("R7", "sram address", sr_addr_o, e.sa);
         check("R4 R6", "packed word", sr_wdata_o, e.wd);
      end
   endtask

   task automatic check_reset_state();
      check("R1", "flash address", fl_addr_o, 0);
      check("R1", "sram address", sr_addr_o, 0);
      check("R1", "read strobe", fl_rd_o, 0);
      check("R1", "write strobe", sr_we_o, 0);
      check("R1", "stage", stage_o, 0);
      check("R1", "done", done_o, 0);
   endtask

   // one full load; a stray start pulse at cycle k_stray must be ignored (R2)
   task automatic run_load(int k_stray);
      int k = 0;
      build_trace();
      @(negedge clk);
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      while (q.size() > 0) begin
         compare(q.pop_front());
         start_i = (k == k_stray);
         k++;
         @(negedge clk);
      end
      start_i = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_reset_state();                       // R1 during reset
      rst_n = 1;
      repeat (3) @(negedge clk);
      check_reset_state();                       // R1 after release, idle without start
      run_load(20);

      // R8: start after completion changes nothing
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      for (int i = 0; i < 30; i++) begin
         check("R8", "done held", done_o, 1);
         check("R8", "stage held", stage_o, 3);
         check("R8", "no read", fl_rd_o, 0);
         check("R8", "no write", sr_we_o, 0);
         @(negedge clk);
      end

      // reset, then a second load with the stray start during warm-up
      rst_n = 0;
      repeat (2) @(negedge clk);
      check_reset_state();
      rst_n = 1;
      repeat (5) @(negedge clk);
      check("R2", "idle stays idle", stage_o, 0);
      run_load(2);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule